// File: doc/BRIEF.md
# Oversampling UART Receiver with Wake-up

This block takes an asynchronous serial line, an enable tick that pulses 16 times per bit period, and a small set of framing controls. It recovers each frame and hands the received word to the next stage as a valid/ready stream. Each frame is a low start bit, 8 or 9 data bits sent least significant bit first, and 1 or 2 high stop bits.

The line passes through a two-flop synchroniser. A frame begins on a high-to-low change seen between two consecutive ticks. Each bit value is the majority of the 7th, 8th and 9th samples inside that bit's 16-sample window. If the start bit does not vote low, the receiver quietly returns to idle.

Once the last stop bit has been voted, the word is placed in a one-entry output buffer and a one-cycle receive pulse is raised. This happens whether or not the stop bits were high. Framing and parity problems raise a separate one-cycle error pulse. A wake-up format lets a receiver ignore every frame whose 9th bit is low.

Top module: `uart_os_rx`

## Requirements
- R1: After reset `out_valid`, `rx_event` and `err_event` are 0.
- R2: A frame starts only on a tick whose synchronised sample is 0 when the previous tick's sample was 1, and only while `run_en` and `rx_en` are both 1. With either control low, no frame is received and no pulse is raised.
- R3: Each bit value is the majority of samples 7, 8 and 9 of its 16-sample window. A single wrong sample, whether inside or outside that window, does not change the bit.
- R4: If the start bit votes 1, the receiver returns to idle without any event and waits for the next falling edge.
- R5: `rx_event` pulses for one clock, in the cycle after the edge that takes the 9th sample of the last stop bit. This holds whatever the stop bits' values. `out_valid` rises one cycle later with the word.
- R6: `fmt` is sampled at the start edge. 0 gives 8 data bits, with `out_data[8]`=0. 1 gives 8 data bits plus a parity bit, which lands in `out_data[8]`. 2 gives 9 data bits. 3 gives 8 data bits plus a wake bit in `out_data[8]`. Data bit i lands in `out_data[i]`. `two_stop`=1, also sampled at the start edge, selects 2 stop bits.
- R7: With `fmt`=3, a frame whose 9th bit votes 0 is dropped: no `rx_event`, no `err_event`, and the output buffer is left unchanged.
- R8: If any stop bit votes 0, `err_event` pulses together with `rx_event`.
- R9: With `fmt`=1 the parity is even. If the XOR of the 8 data bits and the parity bit is 1, `err_event` pulses together with `rx_event`.
- R10: Clearing `rx_en` during a frame lets that frame finish with its events. No later start edge is accepted while `rx_en` is low.
- R11: The receiver accepts a new start edge on the first tick after the last stop bit's 9th sample, so frames that follow one another directly are both received.
- R12: `out_valid` stays 1 and `out_data` stays stable until `out_ready` is 1. A new word arriving while the buffer is full overwrites it (the latest word wins). `out_valid` clears on the cycle after a handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| tick16 | input | 1 | Sample enable, 16 pulses per bit period |
| run_en | input | 1 | Receiver run control |
| rx_en | input | 1 | Receive enable, gates new start edges |
| fmt | input | 2 | Frame format (see R6) |
| two_stop | input | 1 | 1 selects two stop bits |
| out_valid | output | 1 | Output buffer holds a word |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 9 | Received word |
| rx_event | output | 1 | One-cycle receive pulse |
| err_event | output | 1 | One-cycle framing or parity error pulse |

## Verification
The assertions check on every cycle the rules that need no knowledge of the line:
- the receiver stays idle while disarmed;
- the sample position stays inside its window;
- the receive pulse lasts one cycle;
- an error pulse never appears without a receive pulse;
- a delivered wake-format word always has its 9th bit set;
- the stream buffer holds its word under back-pressure.

Only the bench scenarios can show the rest, because each depends on a particular waveform on the line:
- the majority vote rejecting a glitch;
- false starts being dropped;
- the exact cycle of the receive pulse;
- parity and stop-bit errors;
- frames completing after `rx_en` is cleared;
- back-to-back reception.

// File: rtl/uart_osrx_pkg.sv
package uart_osrx_pkg;

  typedef enum logic [1:0] {
    FMT_8    = 2'd0,
    FMT_8P   = 2'd1,
    FMT_9    = 2'd2,
    FMT_WAKE = 2'd3
  } fmt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_osrx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 s,
  input  logic                 arm,
  input  fmt_e                 fmt,
  input  logic                 two_stop,
  output logic                 rx_event,
  output logic                 err_event,
  output logic [DATA_BITS:0]   word
);
  localparam int DW = DATA_BITS + 1;
  localparam int PW = $clog2(OSR + 1);
  localparam int IW = $clog2(DW);
  localparam logic [PW-1:0] V0     = PW'(OSR / 2 - 1);
  localparam logic [PW-1:0] V1     = PW'(OSR / 2);
  localparam logic [PW-1:0] V2     = PW'(OSR / 2 + 1);
  localparam logic [PW-1:0] LASTP  = PW'(OSR);
  localparam logic [PW-1:0] FIRSTP = PW'(1);
  localparam logic [IW-1:0] LAST_SHORT = IW'(DATA_BITS - 1);
  localparam logic [IW-1:0] LAST_LONG  = IW'(DATA_BITS);

  rx_state_e      state;
  fmt_e           fmt_q;
  logic [PW-1:0]  pos, k;
  logic [IW-1:0]  bidx;
  logic [DW-1:0]  shreg;
  logic           v0, v1, last_s, two_q, stop_bad;
  logic           vote, on_mid, on_end, last_stop, finish, keep, ferr, perr, bit_last;

  always_comb begin
    k         = (pos == LASTP) ? FIRSTP : pos + PW'(1);
    vote      = maj3(v0, v1, s);
    on_mid    = tick && (state != ST_IDLE) && (k == V2);
    on_end    = tick && (state != ST_IDLE) && (k == LASTP);
    last_stop = (state == ST_STOP1 && !two_q) || (state == ST_STOP2);
    finish    = on_mid && last_stop;
    ferr      = stop_bad | ~vote;
    perr      = (fmt_q == FMT_8P) && (^shreg);
    keep      = !((fmt_q == FMT_WAKE) && !shreg[DW-1]);
    bit_last  = (bidx == ((fmt_q == FMT_8) ? LAST_SHORT : LAST_LONG));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      fmt_q     <= FMT_8;
      pos       <= FIRSTP;
      bidx      <= '0;
      shreg     <= '0;
      v0        <= 1'b1;
      v1        <= 1'b1;
      last_s    <= 1'b1;
      two_q     <= 1'b0;
      stop_bad  <= 1'b0;
      rx_event  <= 1'b0;
      err_event <= 1'b0;
      word      <= '0;
    end else begin
      rx_event  <= 1'b0;
      err_event <= 1'b0;
      if (tick) begin
        last_s <= s;
        if (state == ST_IDLE) begin
          if (arm && last_s && !s) begin
            state    <= ST_START;
            pos      <= FIRSTP;
            bidx     <= '0;
            shreg    <= '0;
            stop_bad <= 1'b0;
            fmt_q    <= fmt;
            two_q    <= two_stop;
          end
        end else begin
          pos <= k;
          if (k == V0) v0 <= s;
          if (k == V1) v1 <= s;
          case (state)
            ST_START: begin
              if (on_mid && vote) state <= ST_IDLE;
              else if (on_end)    state <= ST_DATA;
            end
            ST_DATA: begin
              if (on_mid) shreg[bidx] <= vote;
              if (on_end) begin
                if (bit_last) state <= ST_STOP1;
                else          bidx  <= bidx + IW'(1);
              end
            end
            ST_STOP1: begin
              if (on_mid && two_q) stop_bad <= ~vote;
              if (on_end && two_q) state    <= ST_STOP2;
            end
            default: ;
          endcase
          if (finish) begin
            state <= ST_IDLE;
            if (keep) begin
              rx_event  <= 1'b1;
              err_event <= ferr | perr;
              word      <= shreg;
            end
          end
        end
      end
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !arm) |=> (state == ST_IDLE));
  // R3
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (pos >= FIRSTP && pos <= LASTP));
  // R5
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_event |=> !rx_event);
  // R8
  err_with_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |-> rx_event);
  // R7
  wake_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_event && fmt_q == FMT_WAKE) |-> word[DW-1]);
endmodule

// File: rtl/rx_out_buf.sv
module rx_out_buf #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R12
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !load) |=> (out_valid && $stable(out_data)));
  // R12
  load_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (out_valid && out_data == $past(load_data)));
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_osrx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rxd,
  input  logic               tick16,
  input  logic               run_en,
  input  logic               rx_en,
  input  logic [1:0]         fmt,
  input  logic               two_stop,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_BITS:0] out_data,
  output logic               rx_event,
  output logic               err_event
);
  localparam int DW = DATA_BITS + 1;

  logic          line_s;
  logic [DW-1:0] word;

  rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .din (rxd),
    .dout (line_s)
  );

  rx_frame_fsm #(.OSR(OSR), .DATA_BITS(DATA_BITS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .s         (line_s),
    .arm       (run_en & rx_en),
    .fmt       (fmt_e'(fmt)),
    .two_stop  (two_stop),
    .rx_event  (rx_event),
    .err_event (err_event),
    .word      (word)
  );

  rx_out_buf #(.DW(DW)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rx_event),
    .load_data (word),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
  );
endmodule

// File: tb/uart_os_rx_test.sv
module uart_os_rx_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0, rxd = 1'b1, tick16 = 1'b0, run_en = 1'b1, rx_en = 1'b1;
  logic [1:0] fmt = 2'd0;
  logic       two_stop = 1'b0, out_ready = 1'b1;
  logic       out_valid, rx_event, err_event;
  logic [8:0] out_data;

  uart_os_rx uut (.clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16), .run_en(run_en),
    .rx_en(rx_en), .fmt(fmt), .two_stop(two_stop), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .rx_event(rx_event), .err_event(err_event));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, evaluated once per clock
  int q0 = 1, q1 = 1, mlast = 1, mst = 0, mpos = 0, mbit = 0, mfmt = 0, mtwo = 0;
  int mword = 0, mstopbad = 0, mrx = 0, merr = 0, mwq = 0, mvld = 0, mdat = 0;
  int smp [1:16];

  always @(posedge clk) begin
    int s, v, k, nb, ferr, perr, keep;
    if (!rst_n) begin
      q0 = 1; q1 = 1; mlast = 1; mst = 0; mpos = 0; mrx = 0; merr = 0; mwq = 0;
      mvld = 0; mdat = 0;
    end else begin
      s = q1; q1 = q0; q0 = int'(rxd);
      if (mrx != 0) begin mvld = 1; mdat = mwq; end
      else if (mvld != 0 && out_ready) mvld = 0;
      mrx = 0; merr = 0;
      if (tick16) begin
        if (mst == 0) begin
          if (run_en && rx_en && mlast == 1 && s == 0) begin
            mst = 1; mpos = 1; smp[1] = s; mfmt = int'(fmt); mtwo = int'(two_stop);
            mword = 0; mbit = 0; mstopbad = 0;
          end
        end else begin
          k = (mpos == 16) ? 1 : mpos + 1;
          mpos = k; smp[k] = s;
          nb = (mfmt == 0) ? 8 : 9;
          if (k == 9) begin
            v = ((smp[7] + smp[8] + smp[9]) >= 2) ? 1 : 0;
            if (mst == 1 && v == 1) mst = 0;
            else if (mst == 2) mword = mword | (v << mbit);
            else if ((mst == 3 && mtwo == 0) || mst == 4) begin
              ferr = (mstopbad != 0 || v == 0) ? 1 : 0;
              perr = (mfmt == 1 && ($countones(mword) % 2) == 1) ? 1 : 0;
              keep = (mfmt == 3 && ((mword >> 8) & 1) == 0) ? 0 : 1;
              if (keep != 0) begin mrx = 1; merr = ferr | perr; mwq = mword; end
              mst = 0;
            end else if (mst == 3) mstopbad = (v == 0) ? 1 : 0;
          end
          if (k == 16 && mst != 0) begin
            if (mst == 1) begin mst = 2; mbit = 0; end
            else if (mst == 2) begin mbit++; if (mbit == nb) mst = 3; end
            else if (mst == 3 && mtwo != 0) mst = 4;
          end
        end
        mlast = s;
      end
    end
  end

  // Cycle compare and event monitor
  int rx_cnt = 0, err_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(rx_event == mrx[0], "R5 rx_event vs model", int'(rx_event), mrx);
      chk(err_event == merr[0], "R8 err_event vs model", int'(err_event), merr);
      chk(out_valid == mvld[0], "R12 out_valid vs model", int'(out_valid), mvld);
      if (mvld != 0) chk(int'(out_data) == mdat, "R12 out_data vs model", int'(out_data), mdat);
      if (rx_event) rx_cnt++;
      if (err_event) err_cnt++;
    end
  end

  task automatic slot(input logic v);
    rxd = v;
    repeat (3) @(posedge clk);
    #1 tick16 = 1'b1;
    @(posedge clk);
    #1 tick16 = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b1);
  endtask

  task automatic send_bit(input logic v, input int gpos, input int len);
    for (int i = 1; i <= len; i++) slot((i == gpos) ? ~v : v);
  endtask

  task automatic send_frame(input logic [8:0] d, input int nb, input int nstop, input logic stopv,
                            input int gbit, input int gpos, input int last_len);
    send_bit(1'b0, (gbit == 0) ? gpos : 0, 16);
    for (int i = 0; i < nb; i++) send_bit(d[i], (gbit == i + 1) ? gpos : 0, 16);
    for (int i = 0; i < nstop; i++)
      send_bit(stopv, (gbit == nb + 1 + i) ? gpos : 0, (i == nstop - 1) ? last_len : 16);
  endtask

  int r0, e0;
  task automatic mark();
    r0 = rx_cnt; e0 = err_cnt;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(out_valid == 1'b0 && rx_event == 1'b0 && err_event == 1'b0, "R1 reset outputs",
        int'({out_valid, rx_event, err_event}), 0);
    rst_n = 1'b1;
    idle(3);

    // R6 basic 8-bit frame
    mark(); send_frame(9'h0A5, 8, 1, 1'b1, -1, 0, 16); idle(2);
    chk(rx_cnt - r0 == 1, "R6 8-bit frame event", rx_cnt - r0, 1);
    chk(out_data == 9'h0A5, "R6 8-bit data", int'(out_data), 'h0A5);
    chk(err_cnt == e0, "R8 no error on good frame", err_cnt - e0, 0);

    // R3 glitches in and out of the vote window
    mark(); send_frame(9'h00F, 8, 1, 1'b1, 4, 8, 16); idle(2);
    chk(out_data == 9'h00F, "R3 glitch at sample 8", int'(out_data), 'h00F);
    send_frame(9'h0F0, 8, 1, 1'b1, 1, 7, 16); idle(1);
    send_frame(9'h0F0, 8, 1, 1'b1, 2, 3, 16); idle(2);
    chk(out_data == 9'h0F0 && rx_cnt - r0 == 3, "R3 glitch at samples 7 and 3",
        int'(out_data), 'h0F0);

    // R4 false start
    mark();
    for (int i = 0; i < 5; i++) slot(1'b0);
    idle(14);
    chk(rx_cnt == r0, "R4 false start ignored", rx_cnt - r0, 0);
    send_frame(9'h03C, 8, 1, 1'b1, -1, 0, 16); idle(2);
    chk(rx_cnt - r0 == 1 && out_data == 9'h03C, "R4 frame after false start",
        int'(out_data), 'h03C);

    // R8 framing error, R5 event regardless of stop value
    mark(); send_frame(9'h011, 8, 1, 1'b0, -1, 0, 16); idle(3);
    chk(rx_cnt - r0 == 1 && out_data == 9'h011, "R5 event with bad stop", rx_cnt - r0, 1);
    chk(err_cnt - e0 == 1, "R8 framing error", err_cnt - e0, 1);

    // R9 parity
    fmt = 2'd1;
    mark(); send_frame(9'h03C, 9, 1, 1'b1, -1, 0, 16); idle(2);
    chk(err_cnt == e0 && out_data == 9'h03C, "R9 good parity", err_cnt - e0, 0);
    mark(); send_frame(9'h13C, 9, 1, 1'b1, -1, 0, 16); idle(2);
    chk(err_cnt - e0 == 1 && out_data == 9'h13C, "R9 bad parity", err_cnt - e0, 1);

    // R6 9-bit frame with two stop bits
    fmt = 2'd2; two_stop = 1'b1;
    mark(); send_frame(9'h1F3, 9, 2, 1'b1, -1, 0, 16); idle(2);
    chk(rx_cnt - r0 == 1 && out_data == 9'h1F3, "R6 9-bit two stops", int'(out_data), 'h1F3);
    mark(); send_frame(9'h0AA, 9, 2, 1'b1, 11, 8, 16); idle(4);
    chk(err_cnt - e0 == 0, "R8 second-stop glitch absorbed", err_cnt - e0, 0);
    two_stop = 1'b0;

    // R7 wake-up format
    fmt = 2'd3;
    mark(); send_frame(9'h055, 9, 1, 1'b1, -1, 0, 16); idle(2);
    chk(rx_cnt == r0 && out_data == 9'h0AA, "R7 wake bit 0 dropped", rx_cnt - r0, 0);
    mark(); send_frame(9'h155, 9, 1, 1'b1, -1, 0, 16); idle(2);
    chk(rx_cnt - r0 == 1 && out_data == 9'h155, "R7 wake bit 1 kept", int'(out_data), 'h155);
    fmt = 2'd0;

    // R2 enables
    mark(); rx_en = 1'b0; send_frame(9'h066, 8, 1, 1'b1, -1, 0, 16); idle(2);
    rx_en = 1'b1; run_en = 1'b0; send_frame(9'h077, 8, 1, 1'b1, -1, 0, 16); idle(2);
    run_en = 1'b1;
    chk(rx_cnt == r0, "R2 disabled frames ignored", rx_cnt - r0, 0);

    // R10 clear rx_en mid-frame
    mark();
    fork
      send_frame(9'h0C3, 8, 1, 1'b1, -1, 0, 16);
      begin repeat (4 * 16 * 3) @(posedge clk); #1 rx_en = 1'b0; end
    join
    idle(2);
    chk(rx_cnt - r0 == 1 && out_data == 9'h0C3, "R10 frame completes", int'(out_data), 'h0C3);
    send_frame(9'h081, 8, 1, 1'b1, -1, 0, 16); idle(2);
    chk(rx_cnt - r0 == 1, "R10 later start ignored", rx_cnt - r0, 1);
    rx_en = 1'b1; idle(2);

    // R11 back-to-back
    mark();
    send_frame(9'h012, 8, 1, 1'b1, -1, 0, 10);
    send_frame(9'h034, 8, 1, 1'b1, -1, 0, 16); idle(2);
    chk(rx_cnt - r0 == 2 && out_data == 9'h034, "R11 back-to-back", rx_cnt - r0, 2);

    // R12 back-pressure
    out_ready = 1'b0;
    send_frame(9'h0E1, 8, 1, 1'b1, -1, 0, 16); idle(3);
    chk(out_valid == 1'b1 && out_data == 9'h0E1, "R12 held under stall", int'(out_data), 'h0E1);
    send_frame(9'h0B2, 8, 1, 1'b1, -1, 0, 16); idle(3);
    chk(out_valid == 1'b1 && out_data == 9'h0B2, "R12 latest word wins", int'(out_data), 'h0B2);
    out_ready = 1'b1;
    repeat (2) @(posedge clk);
    #1 chk(out_valid == 1'b0, "R12 valid clears after handshake", int'(out_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule